// File: doc/BRIEF.md
# Packed SIMD Compare and Flag Unit

This unit takes two 64-bit operands, splits them into lanes of 8, 16 or 32 bits, and applies one lane-wise operation chosen by an opcode. The operations are equality and greater-than compares, minimum and maximum, wrapping add and subtract, and a rounding average. Two interleave forms merge the lanes of both operands, and four widening forms spread half of one operand into lanes of twice the width. Next to the 64-bit result the unit builds a 32-bit status word. It holds a negative flag and a zero flag for every result lane, and where those flags sit depends on the width of the result lanes.

A request is offered by raising `in_valid` together with the opcode, lane size and operands. One clock later `out_valid` rises, with the result and the status word for that request. When no request is offered the outputs keep their last values. The unit suits a media or DSP datapath that wants lane compare masks and per-lane condition flags in a single cycle of latency.

Top module: `simd_cmpflag_unit`

## Requirements
- R1: While `rst_n` is low and after it rises with no request accepted, `out_valid` is 0, `result` is 0 and `status` is 0.
- R2: A cycle with `in_valid` high makes `out_valid` high on the next cycle, with the result and status for that request. A cycle with `in_valid` low makes `out_valid` low on the next cycle, and `result` and `status` keep their values.
- R3: `lane_sz` selects the lane width: 0 = 8 bits, 1 = 16 bits, 2 = 32 bits, 3 = 32 bits. The opcode values 0 to 16 are those listed in R4 to R9. Codes 17 to 31 are reserved and give a result of 0 and a status of 0.
- R4: The compares are equal (0), signed greater-than a>b (1) and unsigned greater-than a>b (2). Each result lane is all ones when its condition holds and all zeros otherwise.
- R5: Signed min (3), unsigned min (4), signed max (5) and unsigned max (6) each copy the a lane when a<b (min) or a>b (max), and copy the b lane otherwise.
- R6: Add (7) gives a+b and subtract (8) gives a-b. Both are taken modulo the lane width, and no carry or borrow crosses into a neighbouring lane.
- R7: Average gives (a+b+r)>>1 on unsigned lanes without losing the carry. Opcode 9 uses r=0 and opcode 10 uses r=1. For the average forms only the zero flags are set, and every negative flag bit is 0.
- R8: Interleave-low (11) takes source lanes j = 0 .. L/2-1, where L is the lane count. Result lane 2j is a lane j and result lane 2j+1 is b lane j. Interleave-high (12) does the same with source lanes L/2+j.
- R9: The widening forms fill result lane j (of twice the lane width) with source lane j of `opa`, using the low half for 13 and 14 and the upper half for 15 and 16. Codes 13 and 15 zero-extend and codes 14 and 16 sign-extend. `opb` has no effect on these forms.
- R10: The width W of the status lanes is the result lane width: the lane width for codes 0 to 12, and twice the lane width for codes 13 to 16 (64 when widening 32-bit lanes). For result lane k, the MSB of that lane goes to status bit (W/2)(k+1)-1 and the "lane equals zero" flag goes to bit (W/2)(k+1)-2. Every other status bit is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request strobe |
| op | input | 5 | Operation code (R3 to R9) |
| lane_sz | input | 2 | Lane width select (R3) |
| opa | input | 64 | Operand a |
| opb | input | 64 | Operand b |
| out_valid | output | 1 | Result of the previous cycle's request is present |
| result | output | 64 | Lane-wise result |
| status | output | 32 | Packed per-lane negative and zero flags |

## Verification
The only state is the output register, so any fault in it shows at the ports on the cycle after the request that loads it. Typical faults are a wrong lane selection, a lost average carry, a misplaced flag bit, or a value captured while idle. The scoreboard compares every result and status word with an independent lane model on that same cycle. On idle cycles it checks that the last values are still held. Directed operands cover the signed/unsigned boundary (0x7F against 0x80), wrap-around to zero, the average carry on all-ones lanes and sign extension. Random operands, some with equal lanes, sweep every opcode and lane size.

// File: rtl/simd_cf_pkg.sv
package simd_cf_pkg;

    typedef enum logic [4:0] {
        OP_EQ       = 5'd0,
        OP_GTS      = 5'd1,
        OP_GTU      = 5'd2,
        OP_MINS     = 5'd3,
        OP_MINU     = 5'd4,
        OP_MAXS     = 5'd5,
        OP_MAXU     = 5'd6,
        OP_ADD      = 5'd7,
        OP_SUB      = 5'd8,
        OP_AVG      = 5'd9,
        OP_AVGR     = 5'd10,
        OP_ILV_LO   = 5'd11,
        OP_ILV_HI   = 5'd12,
        OP_WID_LO_U = 5'd13,
        OP_WID_LO_S = 5'd14,
        OP_WID_HI_U = 5'd15,
        OP_WID_HI_S = 5'd16
    } simd_op_e;

    // number of selectable lane widths (8, 16, 32) and the smallest one
    localparam int NUM_SZ      = 3;
    localparam int BASE_LANE_W = 8;
    // flag layouts: 8, 16, 32 and 64-bit result lanes
    localparam int NUM_FLAG_SZ = NUM_SZ + 1;

    function automatic logic is_lane_op(simd_op_e op);
        return op <= OP_AVGR;
    endfunction

    function automatic logic is_ilv_op(simd_op_e op);
        return (op == OP_ILV_LO) || (op == OP_ILV_HI);
    endfunction

    function automatic logic is_wid_op(simd_op_e op);
        return (op == OP_WID_LO_U) || (op == OP_WID_LO_S) ||
               (op == OP_WID_HI_U) || (op == OP_WID_HI_S);
    endfunction

    function automatic logic is_avg_op(simd_op_e op);
        return (op == OP_AVG) || (op == OP_AVGR);
    endfunction

    function automatic logic is_cmp_op(simd_op_e op);
        return (op == OP_EQ) || (op == OP_GTS) || (op == OP_GTU);
    endfunction

endpackage

// File: rtl/simd_lane_engine.sv
module simd_lane_engine
    import simd_cf_pkg::*;
#(
    parameter int DATA_W = 64,
    parameter int LANE_W = 8
) (
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    input  simd_op_e          op,
    output logic [DATA_W-1:0] res
);
    localparam int LANES = DATA_W / LANE_W;

    logic rnd;
    assign rnd = (op == OP_AVGR);

    for (genvar k = 0; k < LANES; k++) begin : g_lane
        logic [LANE_W-1:0] la, lb, lr;
        logic [LANE_W:0]   avg_sum;
        logic              ugt, ult, sgt, slt, eq;

        assign la = a[k*LANE_W +: LANE_W];
        assign lb = b[k*LANE_W +: LANE_W];

        always_comb begin
            eq      = (la == lb);
            ugt     = (la > lb);
            ult     = (la < lb);
            sgt     = ($signed(la) > $signed(lb));
            slt     = ($signed(la) < $signed(lb));
            // one extra bit keeps the carry of the average sum
            avg_sum = {1'b0, la} + {1'b0, lb} + {{LANE_W{1'b0}}, rnd};
            case (op)
                OP_EQ:   lr = eq  ? '1 : '0;
                OP_GTS:  lr = sgt ? '1 : '0;
                OP_GTU:  lr = ugt ? '1 : '0;
                OP_MINS: lr = slt ? la : lb;
                OP_MINU: lr = ult ? la : lb;
                OP_MAXS: lr = sgt ? la : lb;
                OP_MAXU: lr = ugt ? la : lb;
                OP_ADD:  lr = la + lb;
                OP_SUB:  lr = la - lb;
                OP_AVG,
                OP_AVGR: lr = avg_sum[LANE_W:1];
                default: lr = '0;
            endcase
        end

        assign res[k*LANE_W +: LANE_W] = lr;
    end

endmodule

// File: rtl/simd_lane_permute.sv
module simd_lane_permute
    import simd_cf_pkg::*;
#(
    parameter int DATA_W = 64,
    parameter int LANE_W = 8
) (
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    input  simd_op_e          op,
    output logic [DATA_W-1:0] res
);
    localparam int LANES  = DATA_W / LANE_W;
    localparam int HALF   = LANES / 2;
    localparam int WIDE_W = 2 * LANE_W;

    logic              upper, sext;
    logic [DATA_W-1:0] ilv, wid;

    assign upper = (op == OP_ILV_HI) || (op == OP_WID_HI_U) || (op == OP_WID_HI_S);
    assign sext  = (op == OP_WID_LO_S) || (op == OP_WID_HI_S);

    for (genvar j = 0; j < HALF; j++) begin : g_pair
        logic [LANE_W-1:0] sa, sb;

        assign sa = upper ? a[(HALF+j)*LANE_W +: LANE_W] : a[j*LANE_W +: LANE_W];
        assign sb = upper ? b[(HALF+j)*LANE_W +: LANE_W] : b[j*LANE_W +: LANE_W];

        // interleave: a lane to the even slot, b lane to the odd slot
        assign ilv[(2*j)*LANE_W   +: LANE_W] = sa;
        assign ilv[(2*j+1)*LANE_W +: LANE_W] = sb;

        // widen: one source lane of a per double-width slot
        assign wid[j*WIDE_W +: WIDE_W] = {{LANE_W{sext & sa[LANE_W-1]}}, sa};
    end

    always_comb begin
        case (op)
            OP_ILV_LO, OP_ILV_HI:                  res = ilv;
            OP_WID_LO_U, OP_WID_LO_S,
            OP_WID_HI_U, OP_WID_HI_S:              res = wid;
            default:                               res = '0;
        endcase
    end

endmodule

// File: rtl/simd_flag_pack.sv
module simd_flag_pack
    import simd_cf_pkg::*;
#(
    parameter int DATA_W = 64
) (
    input  logic [DATA_W-1:0]   res,
    input  logic [1:0]          flag_sz,
    input  logic                z_only,
    output logic [DATA_W/2-1:0] status
);
    localparam int SW = DATA_W / 2;

    logic [SW-1:0] cand [NUM_FLAG_SZ];

    for (genvar s = 0; s < NUM_FLAG_SZ; s++) begin : g_layout
        localparam int W  = BASE_LANE_W << s;
        localparam int NL = DATA_W / W;
        logic [SW-1:0] bits;

        always_comb begin
            bits = '0;
            for (int k = 0; k < NL; k++) begin
                bits[(W/2)*(k+1)-1] = res[k*W + W - 1] & ~z_only;
                bits[(W/2)*(k+1)-2] = (res[k*W +: W] == '0);
            end
        end

        assign cand[s] = bits;
    end

    always_comb begin
        status = cand[NUM_FLAG_SZ-1];
        for (int s = 0; s < NUM_FLAG_SZ; s++) begin
            if (flag_sz == 2'(s)) status = cand[s];
        end
    end

endmodule

// File: rtl/simd_cmpflag_unit.sv
module simd_cmpflag_unit
    import simd_cf_pkg::*;
#(
    parameter int DATA_W = 64
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                in_valid,
    input  logic [4:0]          op,
    input  logic [1:0]          lane_sz,
    input  logic [DATA_W-1:0]   opa,
    input  logic [DATA_W-1:0]   opb,
    output logic                out_valid,
    output logic [DATA_W-1:0]   result,
    output logic [DATA_W/2-1:0] status
);
    localparam int SW = DATA_W / 2;
    localparam logic [SW-1:0] N_MASK = {(SW/4){4'b1000}};
    localparam logic [SW-1:0] Z_MASK = {(SW/4){4'b0100}};

    typedef struct packed {
        logic              vld;
        logic [DATA_W-1:0] res;
        logic [SW-1:0]     st;
        simd_op_e          op;
        logic [1:0]        sz;
    } state_t;

    state_t st_d, st_q;

    simd_op_e          op_e;
    logic [1:0]        sz_idx, flag_sz;
    logic [DATA_W-1:0] eng_res [NUM_SZ];
    logic [DATA_W-1:0] prm_res [NUM_SZ];
    logic [DATA_W-1:0] eng_sel, prm_sel, sel_res;
    logic [SW-1:0]     flag_st;
    logic              lane_op, ilv_op, wid_op, avg_op;

    assign op_e    = simd_op_e'(op);
    assign lane_op = is_lane_op(op_e);
    assign ilv_op  = is_ilv_op(op_e);
    assign wid_op  = is_wid_op(op_e);
    assign avg_op  = is_avg_op(op_e);

    // lane size code 3 folds onto the 32-bit lane
    always_comb begin
        case (lane_sz)
            2'd0:    sz_idx = 2'd0;
            2'd1:    sz_idx = 2'd1;
            default: sz_idx = 2'd2;
        endcase
    end

    for (genvar s = 0; s < NUM_SZ; s++) begin : g_size
        simd_lane_engine #(.DATA_W(DATA_W), .LANE_W(BASE_LANE_W << s)) u_eng (
            .a   (opa),
            .b   (opb),
            .op  (op_e),
            .res (eng_res[s])
        );
        simd_lane_permute #(.DATA_W(DATA_W), .LANE_W(BASE_LANE_W << s)) u_prm (
            .a   (opa),
            .b   (opb),
            .op  (op_e),
            .res (prm_res[s])
        );
    end

    always_comb begin
        eng_sel = eng_res[NUM_SZ-1];
        prm_sel = prm_res[NUM_SZ-1];
        for (int s = 0; s < NUM_SZ; s++) begin
            if (sz_idx == 2'(s)) begin
                eng_sel = eng_res[s];
                prm_sel = prm_res[s];
            end
        end
        if (lane_op)                 sel_res = eng_sel;
        else if (ilv_op || wid_op)   sel_res = prm_sel;
        else                         sel_res = '0;
        flag_sz = wid_op ? (sz_idx + 2'd1) : sz_idx;
    end

    simd_flag_pack #(.DATA_W(DATA_W)) u_flags (
        .res     (sel_res),
        .flag_sz (flag_sz),
        .z_only  (avg_op),
        .status  (flag_st)
    );

    always_comb begin
        st_d     = st_q;
        st_d.vld = in_valid;
        if (in_valid) begin
            st_d.res = sel_res;
            st_d.st  = (lane_op || ilv_op || wid_op) ? flag_st : '0;
            st_d.op  = op_e;
            st_d.sz  = sz_idx;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign out_valid = st_q.vld;
    assign result    = st_q.res;
    assign status    = st_q.st;

    // ---------------- assertions ----------------
    function automatic logic bytes_solid(input logic [DATA_W-1:0] v);
        logic ok;
        ok = 1'b1;
        for (int i = 0; i < DATA_W/8; i++)
            if (v[i*8 +: 8] != 8'h00 && v[i*8 +: 8] != 8'hFF) ok = 1'b0;
        return ok;
    endfunction

    function automatic logic odd_bytes_zero(input logic [DATA_W-1:0] v);
        logic ok;
        ok = 1'b1;
        for (int i = 1; i < DATA_W/8; i += 2)
            if (v[i*8 +: 8] != 8'h00) ok = 1'b0;
        return ok;
    endfunction

    p_valid_follows_r2: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    p_idle_clears_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);
    p_idle_holds_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(result) && $stable(status)));
    p_reserved_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && st_q.op > OP_WID_HI_S) |-> (result == '0 && status == '0));
    p_cmp_solid_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && is_cmp_op(st_q.op)) |-> bytes_solid(result));
    p_avg_no_neg_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && is_avg_op(st_q.op)) |-> ((status & N_MASK) == '0));
    p_widen_zero_ext_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && st_q.op == OP_WID_LO_U && st_q.sz == 2'd0) |-> odd_bytes_zero(result));
    p_flag_layout_r10: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> ((status & ~(N_MASK | Z_MASK)) == '0));
    p_flag_exclusive_r10: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (((status >> 1) & status & Z_MASK) == '0));

endmodule

// File: tb/simd_cmpflag_unit_test.sv
module simd_cmpflag_unit_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [4:0]  op = '0;
    logic [1:0]  lane_sz = '0;
    logic [63:0] opa = '0, opb = '0;
    logic        out_valid;
    logic [63:0] result;
    logic [31:0] status;

    int n_chk = 0;
    int n_bad = 0;
    bit mon_on = 0;
    bit have_last = 0;
    logic [63:0] last_r;
    logic [31:0] last_s;

    logic [95:0] q_val [$];
    string       q_tag [$];

    always #4 clk = ~clk;   // 125 MHz

    simd_cmpflag_unit uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op(op), .lane_sz(lane_sz),
        .opa(opa), .opb(opb), .out_valid(out_valid), .result(result), .status(status)
    );

    function automatic longint sx(input logic [63:0] v, input int w);
        if (w < 64 && v[w-1]) return longint'(v) - (longint'(1) <<< w);
        return longint'(v);
    endfunction

    function automatic logic [95:0] model(input logic [4:0] o, input logic [1:0] sz,
                                          input logic [63:0] a, input logic [63:0] b);
        int w, n, fw, base;
        logic [63:0] m, fm, r, la, lb, lr, v;
        logic [31:0] st;
        bit zonly;
        w = (sz == 2'd3) ? 32 : (8 << sz);
        n = 64 / w;
        m = (64'd1 << w) - 64'd1;
        r = '0; st = '0; fw = w; zonly = 0;
        if (o <= 5'd10) begin
            for (int k = 0; k < n; k++) begin
                la = (a >> (k*w)) & m;
                lb = (b >> (k*w)) & m;
                case (o)
                    5'd0: lr = (la == lb) ? m : 64'd0;
                    5'd1: lr = (sx(la, w) > sx(lb, w)) ? m : 64'd0;
                    5'd2: lr = (la > lb) ? m : 64'd0;
                    5'd3: lr = (sx(la, w) < sx(lb, w)) ? la : lb;
                    5'd4: lr = (la < lb) ? la : lb;
                    5'd5: lr = (sx(la, w) > sx(lb, w)) ? la : lb;
                    5'd6: lr = (la > lb) ? la : lb;
                    5'd7: lr = la + lb;
                    5'd8: lr = la - lb;
                    5'd9: lr = (la + lb) >> 1;
                    default: lr = (la + lb + 64'd1) >> 1;
                endcase
                r |= (lr & m) << (k*w);
            end
            zonly = (o >= 5'd9);
        end else if (o <= 5'd12) begin
            base = (o == 5'd12) ? n/2 : 0;
            for (int j = 0; j < n/2; j++) begin
                r |= ((a >> ((base+j)*w)) & m) << (2*j*w);
                r |= ((b >> ((base+j)*w)) & m) << ((2*j+1)*w);
            end
        end else if (o <= 5'd16) begin
            fw = 2*w;
            fm = (fw == 64) ? '1 : ((64'd1 << fw) - 64'd1);
            base = (o >= 5'd15) ? n/2 : 0;
            for (int j = 0; j < n/2; j++) begin
                v = (a >> ((base+j)*w)) & m;
                if ((o == 5'd14 || o == 5'd16) && v[w-1]) v = v | ~m;
                r |= (v & fm) << (j*fw);
            end
        end else begin
            return 96'd0;
        end
        fm = (fw == 64) ? '1 : ((64'd1 << fw) - 64'd1);
        for (int k = 0; k < 64/fw; k++) begin
            v = (r >> (k*fw)) & fm;
            st[(fw/2)*(k+1)-1] = v[fw-1] & ~zonly;
            st[(fw/2)*(k+1)-2] = (v == 64'd0);
        end
        return {r, st};
    endfunction

    function automatic string tag_of(input logic [4:0] o, input logic [1:0] sz);
        if (o > 5'd16)  return "R3";
        if (sz == 2'd3) return "R3";
        if (o <= 5'd2)  return "R4";
        if (o <= 5'd6)  return "R5";
        if (o <= 5'd8)  return "R6";
        if (o <= 5'd10) return "R7";
        if (o <= 5'd12) return "R8";
        return "R9";
    endfunction

    task automatic issue(input logic [4:0] o, input logic [1:0] sz,
                         input logic [63:0] a, input logic [63:0] b);
        @(negedge clk);
        in_valid = 1'b1; op = o; lane_sz = sz; opa = a; opb = b;
        q_val.push_back(model(o, sz, a, b));
        q_tag.push_back(tag_of(o, sz));
    endtask

    task automatic idle(input int cyc);
        for (int i = 0; i < cyc; i++) begin
            @(negedge clk);
            in_valid = 1'b0;
            opa = ~opa; op = 5'd7;   // inputs move while idle (R2)
        end
    endtask

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // monitor: scoreboard side
    initial begin
        forever begin
            @(negedge clk);
            if (mon_on) begin
                if (out_valid) begin
                    if (q_val.size() == 0) begin
                        chk(1'b0, "R2", "unexpected out_valid", 64'd1, 64'd0);
                    end else begin
                        logic [95:0] e;
                        string t;
                        e = q_val.pop_front();
                        t = q_tag.pop_front();
                        chk(result == e[95:32], t, "result", result, e[95:32]);
                        chk(status == e[31:0], "R10", {"status for ", t}, 64'(status), 64'(e[31:0]));
                        last_r = e[95:32]; last_s = e[31:0]; have_last = 1;
                    end
                end else if (have_last) begin
                    chk(result == last_r, "R2", "held result", result, last_r);
                    chk(status == last_s, "R2", "held status", 64'(status), 64'(last_s));
                end
            end
        end
    end

    // watchdog
    initial begin
        repeat (50000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [63:0] ra, rb;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(out_valid == 1'b0, "R1", "out_valid in reset", 64'(out_valid), 64'd0);
        chk(result == 64'd0, "R1", "result in reset", result, 64'd0);
        chk(status == 32'd0, "R1", "status in reset", 64'(status), 64'd0);
        @(negedge clk); rst_n = 1'b1;
        @(negedge clk);
        chk(out_valid == 1'b0 && result == 64'd0 && status == 32'd0, "R1", "after reset",
            {out_valid, result[62:0]}, 64'd0);
        mon_on = 1;

        // R4: signed versus unsigned boundary, equality with zero lanes
        issue(5'd0, 2'd0, 64'h00FF_7F80_1234_0000, 64'h00FF_7F81_1234_0001);
        issue(5'd1, 2'd0, 64'h7F7F_8080_0000_0000, 64'h8080_7F7F_0000_0001);
        issue(5'd2, 2'd0, 64'h7F7F_8080_0000_0000, 64'h8080_7F7F_0000_0001);
        issue(5'd1, 2'd1, 64'h8000_7FFF_0001_FFFF, 64'h7FFF_8000_0000_0000);
        issue(5'd2, 2'd2, 64'h8000_0000_7FFF_FFFF, 64'h7FFF_FFFF_8000_0000);
        // R5: min/max signed and unsigned
        issue(5'd3, 2'd0, 64'h80_7F_01_FF_00_10_20_30, 64'h7F_80_FF_01_00_11_1F_30);
        issue(5'd4, 2'd0, 64'h80_7F_01_FF_00_10_20_30, 64'h7F_80_FF_01_00_11_1F_30);
        issue(5'd5, 2'd1, 64'h8000_7FFF_0001_FFFF, 64'h7FFF_8000_FFFF_0001);
        issue(5'd6, 2'd2, 64'h8000_0000_0000_0001, 64'h7FFF_FFFF_0000_0002);
        idle(2);
        // R6: wrap to zero, borrow, no carry across lanes
        issue(5'd7, 2'd0, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0101_0101_0101_0101);
        issue(5'd8, 2'd1, 64'h0000_0000_8000_0001, 64'h0001_0000_0001_0001);
        issue(5'd7, 2'd2, 64'hFFFF_FFFF_7FFF_FFFF, 64'h0000_0001_0000_0001);
        // R7: carry of the average and the rounding bit
        issue(5'd9,  2'd0, 64'hFFFF_0101_0000_0302, 64'hFFFF_0000_0000_0101);
        issue(5'd10, 2'd0, 64'hFFFF_0101_0000_0302, 64'hFFFF_0000_0000_0101);
        issue(5'd10, 2'd1, 64'hFFFF_8000_0001_0000, 64'hFFFF_8001_0000_0000);
        // R8: interleave low and high at every size
        issue(5'd11, 2'd0, 64'h8877_6655_4433_2211, 64'hFFEE_DDCC_BBAA_0099);
        issue(5'd12, 2'd0, 64'h8877_6655_4433_2211, 64'hFFEE_DDCC_BBAA_0099);
        issue(5'd11, 2'd1, 64'h4444_3333_2222_1111, 64'h8888_7777_6666_0000);
        issue(5'd12, 2'd2, 64'h8000_0000_1111_1111, 64'h0000_0000_2222_2222);
        // R9: zero/sign extension; b varied to show it has no effect
        issue(5'd13, 2'd0, 64'h0102_0304_80FF_7F00, 64'h0);
        issue(5'd14, 2'd0, 64'h0102_0304_80FF_7F00, 64'hFFFF_FFFF_FFFF_FFFF);
        issue(5'd16, 2'd1, 64'h8000_7FFF_0000_0000, 64'h1234_5678_9ABC_DEF0);
        issue(5'd14, 2'd2, 64'h0000_0000_8000_0000, 64'h0);
        issue(5'd14, 2'd2, 64'h0000_0000_8000_0000, 64'hDEAD_BEEF_DEAD_BEEF);
        issue(5'd15, 2'd2, 64'h0000_0000_FFFF_FFFF, 64'h5555);
        idle(1);
        // R3: lane size 3 and reserved codes
        issue(5'd7,  2'd3, 64'hFFFF_FFFF_0000_00FF, 64'h0000_0001_0000_0001);
        issue(5'd17, 2'd0, 64'h1234, 64'h5678);
        issue(5'd31, 2'd1, 64'hFFFF, 64'h0);
        idle(3);

        // random sweep over all codes and sizes
        for (int i = 0; i < 600; i++) begin
            ra = {$urandom, $urandom};
            case ($urandom_range(0, 3))
                0:       rb = ra;
                1:       rb = ra ^ (64'hFF << (8 * $urandom_range(0, 7)));
                default: rb = {$urandom, $urandom};
            endcase
            issue(5'($urandom_range(0, 18)), 2'($urandom_range(0, 3)), ra, rb);
            if ($urandom_range(0, 4) == 0) idle(1);
        end
        idle(3);
        chk(q_val.size() == 0, "R2", "all requests answered", 64'(q_val.size()), 64'd0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule